// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block is the saturating arithmetic stage of a 32-bit processor datapath. Each cycle it can take one instruction word with its two operands, already read from the register file, and produce one result. It recognises four operations in the instruction word: plain saturating add, saturating subtract, and two doubling forms. In a doubling form the second operand is first multiplied by two, with saturation, before the add or subtract. Every result that leaves the signed 32-bit range is clamped to the nearest limit instead of wrapping.

Any clamp, whether in the doubling step or in the final add or subtract, sets a sticky saturation flag. The operations themselves never clear this flag; only reset or the explicit clear input does. An instruction word that matches none of the four opcodes is reported as illegal, and no write is requested for it.

The input side is a plain valid strobe with no back-pressure: the unit accepts a new operation on every cycle, so there is no ready signal. The result, destination index, write enable and illegal indication appear one cycle after the strobe. Fetching the operands from the register file and writing the result back are left to the surrounding datapath.

Top module: `sq_unit`

## Requirements
- R1: With `in_valid` high, the unit decodes `instr` under the mask 0x0FF000F0. The masked pattern 0x01000050 selects add, 0x01200050 subtract, 0x01400050 doubling add and 0x01600050 doubling subtract. Bits outside the mask (condition nibble 31:28, register fields, bits 11:8) do not affect the decode.
- R2: Add returns `op_a + op_b`, computed at full precision and clamped to 0x7FFFFFFF above and 0x80000000 below.
- R3: Subtract returns `op_a - op_b`, with the same clamping.
- R4: The doubling forms first clamp `2*op_b` to the signed 32-bit range. That clamped value, not a wrapped one, is then added to or subtracted from `op_a`, and the sum or difference is clamped again.
- R5: `rd_idx` carries `instr[15:12]` of the accepted legal operation.
- R6: `wr_en` is high for exactly the cycle after a legal operation is accepted, with `result` valid in that cycle. `wr_en` is low in the cycle after `in_valid` is low.
- R7: A valid word that matches no opcode raises `illegal` for one cycle, one cycle later. `wr_en` stays low, `result`, `rd_idx` and `sat_flag` keep their values.
- R8: `sat_flag` (status bit position 27 in the full status word) is set in the cycle after any clamp in either step. No operation clears it.
- R9: Reset clears all outputs. `sat_clr` clears `sat_flag` at the next edge, except that a clamp in the same cycle wins and leaves the flag set.
- R10: There is no back-pressure. Operations on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| instr | input | 32 | Instruction word; opcode under mask 0x0FF000F0, destination in 15:12 |
| op_a | input | 32 | First operand (register named by instr[3:0]) |
| op_b | input | 32 | Second operand (register named by instr[19:16]) |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| result | output | 32 | Saturated result |
| rd_idx | output | 4 | Destination register index |
| wr_en | output | 1 | Register write request for result |
| illegal | output | 1 | The accepted word matched no opcode |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A wrong clamp shows in `result` one cycle after the operation, either as a wrapped value or as the wrong limit. The doubling cases are picked so that feeding the wrapped double instead of the clamped one flips the final limit. A flag that is lost or set spuriously is visible on `sat_flag` in that same cycle and stays wrong until the next clear, because the flag is sticky. The scoreboard therefore compares the flag after every operation, not only after clamping ones. A decode fault shows up as `illegal` or `wr_en` taking the wrong value in the cycle after the strobe.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int INSN_W = 32;
  localparam int N_OPS  = 4;
  localparam logic [INSN_W-1:0] SQ_MASK = 32'h0FF0_00F0;
  // index order: add, sub, doubling add, doubling sub
  localparam logic [N_OPS-1:0][INSN_W-1:0] SQ_PATS = {
    32'h0160_0050, 32'h0140_0050, 32'h0120_0050, 32'h0100_0050
  };
  localparam int RD_LO = 12;
  localparam int RD_W  = 4;

  typedef struct packed {
    logic legal;
    logic dbl;
    logic sub;
  } sq_op_t;
endpackage

// File: rtl/sq_decode.sv
module sq_decode
  import sq_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output sq_op_t            op
);
  logic [N_OPS-1:0] hit;

  for (genvar i = 0; i < N_OPS; i++) begin : g_match
    assign hit[i] = ((instr & SQ_MASK) == SQ_PATS[i]);
  end

  always_comb begin
    op.legal = |hit;
    op.sub   = hit[1] | hit[3];
    op.dbl   = hit[2] | hit[3];
  end
endmodule

// File: rtl/sq_clamp.sv
module sq_clamp #(
  parameter int W = 32
) (
  input  logic [W+1:0] wide,
  output logic [W-1:0] narrow,
  output logic         ovf
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  // in range only if the top three bits agree
  always_comb begin
    ovf = !((wide[W+1:W-1] == 3'b000) || (wide[W+1:W-1] == 3'b111));
    if (!ovf)          narrow = wide[W-1:0];
    else if (wide[W+1]) narrow = NEG_LIM;
    else               narrow = POS_LIM;
  end
endmodule

// File: rtl/sq_satcore.sv
module sq_satcore #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         dbl,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int XW = W + 2;

  logic [XW-1:0] a_x, b_x, dbl_x, sel_x, sum_x;
  logic [W-1:0]  dbl_sat, sel;
  logic          dbl_ovf, sum_ovf;

  assign a_x   = {{2{a[W-1]}}, a};
  assign b_x   = {{2{b[W-1]}}, b};
  assign dbl_x = {b_x[XW-2:0], 1'b0};

  sq_clamp #(.W(W)) u_dbl_clamp (
    .wide(dbl_x), .narrow(dbl_sat), .ovf(dbl_ovf)
  );

  assign sel   = dbl ? dbl_sat : b;
  assign sel_x = {{2{sel[W-1]}}, sel};
  assign sum_x = sub ? (a_x - sel_x) : (a_x + sel_x);

  sq_clamp #(.W(W)) u_sum_clamp (
    .wide(sum_x), .narrow(res), .ovf(sum_ovf)
  );

  assign sat = (dbl & dbl_ovf) | sum_ovf;
endmodule

// File: rtl/sq_unit.sv
module sq_unit
  import sq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [INSN_W-1:0]   instr,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic                sat_clr,
  output logic [DATA_W-1:0]   result,
  output logic [RD_W-1:0]     rd_idx,
  output logic                wr_en,
  output logic                illegal,
  output logic                sat_flag
);
  sq_op_t          op;
  logic [DATA_W-1:0] core_res;
  logic            core_sat;
  logic            take;

  sq_decode u_dec (.instr(instr), .op(op));

  sq_satcore #(.W(DATA_W)) u_core (
    .a(op_a), .b(op_b), .dbl(op.dbl), .sub(op.sub),
    .res(core_res), .sat(core_sat)
  );

  assign take = in_valid & op.legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      rd_idx   <= '0;
      wr_en    <= 1'b0;
      illegal  <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      wr_en   <= take;
      illegal <= in_valid & ~op.legal;
      if (take) begin
        result <= core_res;
        rd_idx <= instr[RD_LO +: RD_W];
      end
      // a clamp in the same cycle wins over a clear
      if (take && core_sat) sat_flag <= 1'b1;
      else if (sat_clr)     sat_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sq_unit_chk.sv
module sq_unit_chk
  import sq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] instr,
  input logic              sat_clr,
  input logic [DATA_W-1:0] result,
  input logic [RD_W-1:0]   rd_idx,
  input logic              wr_en,
  input logic              illegal,
  input logic              sat_flag
);
  logic known;
  assign known = ((instr & SQ_MASK) == 32'h0100_0050) ||
                 ((instr & SQ_MASK) == 32'h0120_0050) ||
                 ((instr & SQ_MASK) == 32'h0140_0050) ||
                 ((instr & SQ_MASK) == 32'h0160_0050);

  // R1
  legal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && known |=> wr_en && !illegal);

  // R5
  dest_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && known |=> rd_idx == $past(instr[15:12]));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_en && !illegal);

  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !known |=> illegal && !wr_en && $stable(result) && $stable(rd_idx));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> wr_en);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !in_valid |=> !sat_flag);
endmodule

bind sq_unit sq_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .sat_clr(sat_clr), .result(result), .rd_idx(rd_idx), .wr_en(wr_en),
  .illegal(illegal), .sat_flag(sat_flag)
);

// File: tb/sq_unit_test.sv
module sq_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] instr = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sat_clr = 0;
  logic [31:0] result;
  logic [3:0]  rd_idx;
  logic        wr_en, illegal, sat_flag;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [31:0] P_ADD = 32'h0100_0050;
  localparam logic [31:0] P_SUB = 32'h0120_0050;
  localparam logic [31:0] P_DAD = 32'h0140_0050;
  localparam logic [31:0] P_DSB = 32'h0160_0050;
  localparam logic [31:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [31:0] MINN = 32'h8000_0000;

  always #(PERIOD/2) clk = ~clk;

  sq_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .sat_clr(sat_clr), .result(result),
    .rd_idx(rd_idx), .wr_en(wr_en), .illegal(illegal), .sat_flag(sat_flag)
  );

  typedef struct {
    bit          wr;
    bit          ill;
    logic [31:0] res;
    logic [3:0]  rd;
    bit          flag;
    string       tag;
  } exp_t;

  exp_t sb[$];

  logic [31:0] m_res = '0;
  logic [3:0]  m_rd = '0;
  bit          m_flag = 0;

  // returns {overflow, clamped value}
  function automatic logic [32:0] sat32(longint x);
    if (x > 64'sd2147483647)  return {1'b1, MAXP};
    if (x < -64'sd2147483648) return {1'b1, MINN};
    return {1'b0, x[31:0]};
  endfunction

  task automatic drive(bit v, logic [31:0] ins, logic [31:0] a,
                       logic [31:0] b, bit clr, string tag);
    exp_t e;
    logic [31:0] k;
    logic [32:0] d, s;
    longint sa, sb2;
    bit legal, dbl, sub, hit;
    @(negedge clk);
    in_valid = v; instr = ins; op_a = a; op_b = b; sat_clr = clr;
    k = ins & 32'h0FF0_00F0;
    legal = (k == P_ADD) || (k == P_SUB) || (k == P_DAD) || (k == P_DSB);
    dbl = (k == P_DAD) || (k == P_DSB);
    sub = (k == P_SUB) || (k == P_DSB);
    hit = 0;
    if (v && legal) begin
      sa = longint'($signed(a));
      d  = sat32(longint'($signed(b)) * 2);
      sb2 = dbl ? longint'($signed(d[31:0])) : longint'($signed(b));
      s  = sat32(sub ? sa - sb2 : sa + sb2);
      hit = s[32] | (dbl & d[32]);
      m_res = s[31:0];
      m_rd  = ins[15:12];
    end
    if (v && legal && hit) m_flag = 1;
    else if (clr)          m_flag = 0;
    e.wr = v && legal; e.ill = v && !legal;
    e.res = m_res; e.rd = m_rd; e.flag = m_flag; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic op(logic [31:0] pat, logic [3:0] rd, logic [31:0] a,
                    logic [31:0] b, string tag);
    drive(1, pat | (32'(rd) << 12) | 32'h0000_0203, a, b, 0, tag);
  endtask

  // monitor: samples shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (wr_en !== e.wr || illegal !== e.ill || result !== e.res ||
          rd_idx !== e.rd || sat_flag !== e.flag) begin
        fails++;
        $display("FAIL %s: got wr=%0b ill=%0b res=%h rd=%0d flag=%0b, exp wr=%0b ill=%0b res=%h rd=%0d flag=%0b",
          e.tag, wr_en, illegal, result, rd_idx, sat_flag,
          e.wr, e.ill, e.res, e.rd, e.flag);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (result !== 0 || rd_idx !== 0 || wr_en !== 0 || illegal !== 0 || sat_flag !== 0) begin
      fails++;
      $display("FAIL R9 reset: got res=%h rd=%0d wr=%0b ill=%0b flag=%0b, exp all zero",
        result, rd_idx, wr_en, illegal, sat_flag);
    end

    // R2 add
    op(P_ADD, 4'd1, 32'd5, 32'd7, "R2 add small");
    op(P_ADD, 4'd2, 32'hFFFF_FFF0, 32'd3, "R2 add negative");
    op(P_ADD, 4'd3, MAXP, 32'd1, "R2 R8 add clamp high");
    drive(0, '0, '0, '0, 0, "R6 idle after op");
    op(P_ADD, 4'd4, 32'd1, 32'd1, "R8 flag stays set");
    drive(0, '0, '0, '0, 1, "R9 clear");
    op(P_ADD, 4'd5, MINN, 32'hFFFF_FFFF, "R2 add clamp low");
    // R9 clear and clamp same cycle: clamp wins
    drive(1, P_SUB | 32'h0000_6000, MINN, 32'd1, 1, "R3 R9 sub clamp beats clear");
    drive(0, '0, '0, '0, 1, "R9 clear again");
    // R3 subtract
    op(P_SUB, 4'd7, 32'd10, 32'd3, "R3 sub");
    op(P_SUB, 4'd8, 32'd3, 32'd10, "R3 sub order");
    op(P_SUB, 4'd9, MAXP, 32'hFFFF_FFFF, "R3 sub clamp high");
    drive(0, '0, '0, '0, 1, "R9 clear");
    // R4 doubling
    op(P_DAD, 4'd10, 32'd1, 32'd3, "R4 doubling add");
    op(P_DAD, 4'd11, 32'hFFFF_FFFB, 32'h4000_0000, "R4 double clamp only");
    drive(0, '0, '0, '0, 1, "R9 clear");
    op(P_DSB, 4'd12, 32'd0, 32'h4000_0000, "R4 dsub clamped double");
    drive(0, '0, '0, '0, 1, "R9 clear");
    op(P_DSB, 4'd13, 32'd0, 32'hC000_0000, "R4 dsub exact double, final clamp");
    drive(0, '0, '0, '0, 1, "R9 clear");
    op(P_DSB, 4'd14, 32'd100, 32'd20, "R4 dsub plain");
    op(P_DAD, 4'd15, MINN, 32'h8000_0000, "R4 dadd both clamp low");
    drive(0, '0, '0, '0, 1, "R9 clear");
    // R1 decode ignores unmasked fields
    drive(1, 32'hE12F_3F05 & ~32'h000F_0000 | P_SUB | 32'h000F_0000, 32'd50, 32'd8, 0,
          "R1 free fields ignored");
    // R7 illegal words
    drive(1, 32'h0100_0090, 32'h7FFF_FFFF, 32'd9, 0, "R7 illegal no write");
    drive(1, 32'h0130_0050, MAXP, MAXP, 0, "R7 illegal no flag");
    drive(0, '0, '0, '0, 0, "R7 R6 idle");
    // R10 back-to-back
    for (int i = 0; i < 6; i++)
      op((i % 2) ? P_SUB : P_ADD, 4'(i), 32'(i * 1000), 32'(i * 7), "R10 back-to-back");
    op(P_ADD, 4'd6, MAXP, MAXP, "R10 R8 clamp in stream");
    op(P_SUB, 4'd5, 32'd2, 32'd1, "R10 R5 after clamp");
    drive(0, '0, '0, '0, 0, "R6 idle end");
    drive(0, '0, '0, '0, 0, "R6 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule